// File: doc/BRIEF.md
# Multi-Buffer CAN Receive Allocator

This block holds received CAN data frames in a bank of message slots. Each slot carries a 29-bit filter identifier, a 29-bit ignore mask (a 1 bit means that identifier position is not compared) and an interrupt-enable bit. All enabled slots whose filter accepts an arriving identifier make up the candidate group for that frame. The frame is written into the lowest-indexed candidate that holds no unread data. Slots programmed with one identifier therefore fill in order, like a hardware ring. The CPU never has to step in, and no unread frame is ever overwritten.

The host programs slots through a configuration strobe. It acknowledges frames by clearing a slot's data-new flag and reads stored frames through a combinational read port. A frame that reaches a group whose slots are all full is dropped and raises a sticky overflow flag. Giving the interrupt enable only to the last slot of a group makes the host hear about a whole block of frames at once.

Each slot runs a three-state machine:
- SLOT_OFF: the slot does not receive.
- SLOT_FREE: the slot is enabled and empty.
- SLOT_FULL: the slot holds an unread frame.

The transitions are:
- CFG_ON: a configuration write with enable set leads to SLOT_FREE from any state.
- CFG_OFF: a configuration write with enable clear leads to SLOT_OFF from any state.
- STORE: SLOT_FREE goes to SLOT_FULL when the slot is granted a frame.
- ACK: SLOT_FULL goes to SLOT_FREE when the host clears data-new.

A configuration write takes priority over ACK and STORE.

Top module: `can_mbrx_top`

## Requirements
- R1: After reset all data-new flags, the overflow flag and the interrupt are 0, and every slot is in SLOT_OFF.
- R2: A frame is accepted by a slot when every identifier bit whose mask bit is 0 equals the slot's filter bit; identifier bits whose mask bit is 1 are not compared.
- R3: A slot in SLOT_OFF never stores a frame, even if its filter matches.
- R4: An accepted frame is written into the lowest-indexed candidate slot in SLOT_FREE: identifier, 4-bit DLC and 64-bit payload are written and data-new is set at the clock edge where rx_valid is sampled high, and the frame is then readable through the read port.
- R5: Successive matching frames fill successive free slots of the group in ascending index order; a slot with data-new set is never overwritten.
- R6: A frame that has candidates but no free candidate is dropped, leaving all slots unchanged, and sets ovf; ovf stays 1 until a cycle with ovf_clr high and no new overflow.
- R7: irq is high for exactly the one cycle after a store, and only if the receiving slot's interrupt-enable bit is 1.
- R8: A host clear (clr_we with clr_idx) moves a full slot back to SLOT_FREE; the next frame goes to the lowest free candidate again, not to the slot after the last one written.
- R9: A configuration write clears the slot's data-new flag and places it in SLOT_FREE (cfg_en=1) or SLOT_OFF (cfg_en=0); a slot being configured takes no frame in that cycle.
- R10: A frame matching no enabled slot changes no data-new flag and does not set ovf.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | One-cycle strobe of a received data frame |
| rx_id | input | 29 | Received identifier |
| rx_dlc | input | 4 | Received data length code |
| rx_data | input | 64 | Received payload, byte 0 in bits 7:0 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Slot selected for configuration |
| cfg_id | input | 29 | Filter identifier to program |
| cfg_mask | input | 29 | Ignore mask to program (1 = not compared) |
| cfg_en | input | 1 | Slot receive enable to program |
| cfg_ie | input | 1 | Slot interrupt enable to program |
| clr_we | input | 1 | Host clear of one slot's data-new flag |
| clr_idx | input | 3 | Slot to clear |
| ovf_clr | input | 1 | Write-1 clear of the overflow flag |
| rd_idx | input | 3 | Slot selected on the read port |
| rd_id | output | 29 | Stored identifier of the selected slot |
| rd_dlc | output | 4 | Stored DLC of the selected slot |
| rd_data | output | 64 | Stored payload of the selected slot |
| dn | output | 8 | Per-slot data-new flags |
| ovf | output | 1 | Sticky overflow flag |
| irq | output | 1 | One-cycle reception interrupt |

## Verification
The assertions rely on these input conditions:
- rx_valid is a single-cycle strobe.
- clr_idx and cfg_idx point inside the bank.
- The host does not reconfigure a slot while relying on its unread contents.

Under those conditions, a granted slot must be in SLOT_FREE, at most one slot is granted, and no grant ever lands on a flagged slot. The stimulus drives all inputs on the falling edge. It raises rx_valid for one cycle at a time, separated by idle cycles. It changes configuration only between frames, except in the case that checks the configuration-priority rule.

// File: rtl/can_mbrx_pkg.sv
package can_mbrx_pkg;
    localparam int CAN_ID_W   = 29;
    localparam int CAN_DLC_W  = 4;
    localparam int CAN_DATA_W = 64;

    typedef enum logic [1:0] {
        SLOT_OFF  = 2'd0,
        SLOT_FREE = 2'd1,
        SLOT_FULL = 2'd2
    } slot_st_e;
endpackage

// File: rtl/can_mbrx_match.sv
module can_mbrx_match #(
    parameter int ID_W = 29
) (
    input  logic            en,
    input  logic [ID_W-1:0] rx_id,
    input  logic [ID_W-1:0] filt_id,
    input  logic [ID_W-1:0] filt_mask,
    output logic            hit
);
    logic [ID_W-1:0] diff;

    always_comb begin
        diff = (rx_id ^ filt_id) & ~filt_mask;
        hit  = en && (diff == '0);
    end
endmodule

// File: rtl/can_mbrx_pick.sv
module can_mbrx_pick #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] elig,
    output logic [N-1:0] grant
);
    always_comb begin
        grant = elig & (~elig + {{(N-1){1'b0}}, 1'b1});
    end

    // R4
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
endmodule

// File: rtl/can_mbrx_slot.sv
module can_mbrx_slot
    import can_mbrx_pkg::*;
#(
    parameter int ID_W   = CAN_ID_W,
    parameter int DLC_W  = CAN_DLC_W,
    parameter int DATA_W = CAN_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_sel,
    input  logic              cfg_en,
    input  logic              cfg_ie,
    input  logic [ID_W-1:0]   cfg_id,
    input  logic [ID_W-1:0]   cfg_mask,
    input  logic              ack,
    input  logic              wr_en,
    input  logic [ID_W-1:0]   rx_id,
    input  logic [DLC_W-1:0]  rx_dlc,
    input  logic [DATA_W-1:0] rx_data,
    output logic              en,
    output logic              free,
    output logic              dn,
    output logic              ie,
    output logic [ID_W-1:0]   filt_id,
    output logic [ID_W-1:0]   filt_mask,
    output logic [ID_W-1:0]   st_id,
    output logic [DLC_W-1:0]  st_dlc,
    output logic [DATA_W-1:0] st_data
);
    slot_st_e state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (cfg_sel) begin
            state_d = cfg_en ? SLOT_FREE : SLOT_OFF;
        end else begin
            unique case (state_q)
                SLOT_OFF:  state_d = SLOT_OFF;
                SLOT_FREE: if (wr_en) state_d = SLOT_FULL;
                SLOT_FULL: if (ack)   state_d = SLOT_FREE;
                default:   state_d = SLOT_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_OFF;
        else        state_q <= state_d;
    end

    // outputs decoded from state
    always_comb begin
        en   = 1'b0;
        free = 1'b0;
        dn   = 1'b0;
        unique case (state_q)
            SLOT_OFF:  ;
            SLOT_FREE: begin en = 1'b1; free = 1'b1; end
            SLOT_FULL: begin en = 1'b1; dn = 1'b1; end
            default:   ;
        endcase
    end

    // filter programming
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_id   <= '0;
            filt_mask <= '0;
            ie        <= 1'b0;
        end else if (cfg_sel) begin
            filt_id   <= cfg_id;
            filt_mask <= cfg_mask;
            ie        <= cfg_ie;
        end
    end

    // frame storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_id   <= '0;
            st_dlc  <= '0;
            st_data <= '0;
        end else if (wr_en && !cfg_sel) begin
            st_id   <= rx_id;
            st_dlc  <= rx_dlc;
            st_data <= rx_data;
        end
    end

    // R5
    slot_wr_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (state_q == SLOT_FREE));

    // R9
    cfg_clears_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_sel |=> !dn);
endmodule

// File: rtl/can_mbrx_top.sv
module can_mbrx_top
    import can_mbrx_pkg::*;
#(
    parameter int NBUF   = 8,
    parameter int ID_W   = CAN_ID_W,
    parameter int DLC_W  = CAN_DLC_W,
    parameter int DATA_W = CAN_DATA_W,
    localparam int IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [ID_W-1:0]   rx_id,
    input  logic [DLC_W-1:0]  rx_dlc,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ID_W-1:0]   cfg_id,
    input  logic [ID_W-1:0]   cfg_mask,
    input  logic              cfg_en,
    input  logic              cfg_ie,
    input  logic              clr_we,
    input  logic [IDX_W-1:0]  clr_idx,
    input  logic              ovf_clr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ID_W-1:0]   rd_id,
    output logic [DLC_W-1:0]  rd_dlc,
    output logic [DATA_W-1:0] rd_data,
    output logic [NBUF-1:0]   dn,
    output logic              ovf,
    output logic              irq
);
    logic [NBUF-1:0] cfg_sel, ack, en_v, free_v, ie_v, hit_v, cand, elig, grant;
    logic [ID_W-1:0]   f_id   [NBUF];
    logic [ID_W-1:0]   f_mask [NBUF];
    logic [ID_W-1:0]   s_id   [NBUF];
    logic [DLC_W-1:0]  s_dlc  [NBUF];
    logic [DATA_W-1:0] s_data [NBUF];
    logic ovf_q, irq_q, drop;

    for (genvar i = 0; i < NBUF; i++) begin : g_slot
        assign cfg_sel[i] = cfg_we && (cfg_idx == IDX_W'(i));
        assign ack[i]     = clr_we && (clr_idx == IDX_W'(i));

        can_mbrx_slot #(.ID_W(ID_W), .DLC_W(DLC_W), .DATA_W(DATA_W)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .cfg_sel(cfg_sel[i]), .cfg_en(cfg_en), .cfg_ie(cfg_ie),
            .cfg_id(cfg_id), .cfg_mask(cfg_mask),
            .ack(ack[i]), .wr_en(grant[i]),
            .rx_id(rx_id), .rx_dlc(rx_dlc), .rx_data(rx_data),
            .en(en_v[i]), .free(free_v[i]), .dn(dn[i]), .ie(ie_v[i]),
            .filt_id(f_id[i]), .filt_mask(f_mask[i]),
            .st_id(s_id[i]), .st_dlc(s_dlc[i]), .st_data(s_data[i])
        );

        can_mbrx_match #(.ID_W(ID_W)) u_match (
            .en(en_v[i]), .rx_id(rx_id),
            .filt_id(f_id[i]), .filt_mask(f_mask[i]),
            .hit(hit_v[i])
        );
    end

    always_comb begin
        cand = hit_v & ~cfg_sel & {NBUF{rx_valid}};
        elig = cand & free_v;
        drop = (|cand) && !(|elig);
    end

    can_mbrx_pick #(.N(NBUF)) u_pick (
        .clk(clk), .rst_n(rst_n), .elig(elig), .grant(grant)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(grant & ie_v);
            if (drop)         ovf_q <= 1'b1;
            else if (ovf_clr) ovf_q <= 1'b0;
        end
    end

    always_comb begin
        ovf     = ovf_q;
        irq     = irq_q;
        rd_id   = s_id[rd_idx];
        rd_dlc  = s_dlc[rd_idx];
        rd_data = s_data[rd_idx];
    end

    // R5
    no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |-> ((grant & dn) == '0));

    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);

    // R7
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(rx_valid));

    // R3
    off_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~en_v) == '0);
endmodule

// File: tb/tb_can_mbrx_top.sv
`timescale 1ns/1ps
module tb_can_mbrx_top;
    localparam int NB = 8;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 0, cfg_we = 0, cfg_en = 0, cfg_ie = 0, clr_we = 0, ovf_clr = 0;
    logic [28:0] rx_id = '0, cfg_id = '0, cfg_mask = '0;
    logic [3:0]  rx_dlc = '0;
    logic [63:0] rx_data = '0;
    logic [2:0]  cfg_idx = '0, clr_idx = '0, rd_idx = '0;
    logic [28:0] rd_id;
    logic [3:0]  rd_dlc;
    logic [63:0] rd_data;
    logic [NB-1:0] dn;
    logic ovf, irq;
    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    can_mbrx_top dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_id(rx_id),
        .rx_dlc(rx_dlc), .rx_data(rx_data), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_id(cfg_id), .cfg_mask(cfg_mask), .cfg_en(cfg_en), .cfg_ie(cfg_ie),
        .clr_we(clr_we), .clr_idx(clr_idx), .ovf_clr(ovf_clr), .rd_idx(rd_idx),
        .rd_id(rd_id), .rd_dlc(rd_dlc), .rd_data(rd_data), .dn(dn),
        .ovf(ovf), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg(input int idx, input logic [28:0] id, input logic [28:0] m, input bit en, input bit ie);
        @(negedge clk);
        cfg_we = 1; cfg_idx = 3'(idx); cfg_id = id; cfg_mask = m; cfg_en = en; cfg_ie = ie;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic send(input logic [28:0] id, input logic [3:0] dlc, input logic [63:0] d);
        @(negedge clk);
        rx_valid = 1; rx_id = id; rx_dlc = dlc; rx_data = d;
        @(negedge clk);
        rx_valid = 0;
    endtask

    task automatic clr(input int idx);
        @(negedge clk);
        clr_we = 1; clr_idx = 3'(idx);
        @(negedge clk);
        clr_we = 0;
    endtask

    function automatic logic [63:0] pay(input int n);
        return 64'h0123_4567_89AB_CDEF ^ (64'(n) * 64'h1111_1111_1111_1111);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [28:0] base, gid;
        logic [NB-1:0] exp_dn;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(dn == '0, "R1 dn", 64'(dn), 0);
        chk(ovf == 0, "R1 ovf", 64'(ovf), 0);
        chk(irq == 0, "R1 irq", 64'(irq), 0);
        rst_n = 1;
        // R1: no slot receives straight after reset (all off)
        send(29'h0, 4'd1, 64'h1);
        chk(dn == '0, "R1 slots off", 64'(dn), 0);

        // R2 / R10 sweep over every identifier bit
        base = 29'h0A5A_5A5A;
        for (int b = 0; b < 29; b++) begin
            cfg(0, base, 29'(1) << b, 1, 0);
            send(base ^ (29'(1) << b), 4'd2, 64'(b));
            chk(dn[0] == 1, "R2 masked bit ignored", 64'(dn), 1);
            cfg(0, base, 29'h0, 1, 0);
            send(base ^ (29'(1) << b), 4'd2, 64'(b));
            chk(dn == '0, "R10 unmasked mismatch rejected", 64'(dn), 0);
            chk(ovf == 0, "R10 no ovf on miss", 64'(ovf), 0);
        end

        // R3 disabled slot
        cfg(0, base, 29'h0, 0, 1);
        cfg(1, base, 29'h0, 0, 1);
        send(base, 4'd3, 64'h33);
        chk(dn == '0, "R3 disabled slots", 64'(dn), 0);
        chk(irq == 0, "R3 no irq", 64'(irq), 0);

        // group on slots 2..5, ie only on slot 5
        gid = 29'h1234_5678;
        for (int s = 2; s <= 5; s++) cfg(s, gid, 29'h0, 1, s == 5);
        exp_dn = '0;
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            rx_valid = 1; rx_id = gid; rx_dlc = 4'(n + 5); rx_data = pay(n);
            @(negedge clk);
            rx_valid = 0;
            exp_dn[n + 2] = 1'b1;
            chk(dn == exp_dn, "R5 fill order", 64'(dn), 64'(exp_dn));
            chk(irq == (n == 3), "R7 irq only from enabled slot", 64'(irq), 64'(n == 3));
            rd_idx = 3'(n + 2);
            #0.1;
            chk(rd_data == pay(n), "R4 stored payload", rd_data, pay(n));
            chk(rd_dlc == 4'(n + 5) && rd_id == gid, "R4 stored dlc/id", 64'(rd_dlc), 64'(n + 5));
            @(negedge clk);
            chk(irq == 0, "R7 irq one cycle", 64'(irq), 0);
        end

        // R6 overflow
        send(gid, 4'd15, 64'hDEAD);
        chk(ovf == 1, "R6 ovf set", 64'(ovf), 1);
        chk(dn == exp_dn, "R6 dn unchanged", 64'(dn), 64'(exp_dn));
        rd_idx = 3'd2; #0.1;
        chk(rd_data == pay(0), "R6 no overwrite", rd_data, pay(0));
        repeat (5) @(negedge clk);
        chk(ovf == 1, "R6 ovf sticky", 64'(ovf), 1);
        @(negedge clk); ovf_clr = 1; @(negedge clk); ovf_clr = 0;
        chk(ovf == 0, "R6 ovf cleared", 64'(ovf), 0);

        // R8 clear and restart from lowest
        clr(4);
        clr(2);
        chk(dn == 8'b0010_1000, "R8 clear", 64'(dn), 64'h28);
        send(gid, 4'd1, pay(10));
        chk(dn == 8'b0010_1100, "R8 lowest free first", 64'(dn), 64'h2C);
        rd_idx = 3'd2; #0.1;
        chk(rd_data == pay(10), "R8 data in slot 2", rd_data, pay(10));
        send(gid, 4'd1, pay(11));
        chk(dn == 8'b0011_1100, "R8 next free slot 4", 64'(dn), 64'h3C);
        rd_idx = 3'd4; #0.1;
        chk(rd_data == pay(11), "R8 data in slot 4", rd_data, pay(11));

        // R9 reconfiguration clears dn; configure beats frame in same cycle
        clr(3);
        @(negedge clk);
        cfg_we = 1; cfg_idx = 3'd3; cfg_id = gid; cfg_mask = 0; cfg_en = 1; cfg_ie = 0;
        rx_valid = 1; rx_id = gid; rx_data = pay(20);
        @(negedge clk);
        cfg_we = 0; rx_valid = 0;
        chk(dn[3] == 0, "R9 configured slot skipped", 64'(dn), 0);
        chk(ovf == 1, "R9 drop when only slot is configuring", 64'(ovf), 1);
        @(negedge clk); ovf_clr = 1; @(negedge clk); ovf_clr = 0;
        cfg(5, gid, 29'h0, 0, 0);
        chk(dn[5] == 0, "R9 cfg clears dn", 64'(dn), 0);
        send(gid, 4'd2, pay(21));
        chk(dn == 8'b0001_1100, "R9 freed slot 3 receives", 64'(dn), 64'h1C);

        // R10 non-matching frame leaves everything
        send(~gid, 4'd2, 64'h77);
        chk(dn == 8'b0001_1100 && ovf == 0, "R10 no effect", 64'(dn), 64'h1C);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule